// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns an idle-high asynchronous serial line into whole characters. A shared tick supplies the bit timing; the tick fires sixteen times per bit period. The frame format is set at run time through configuration inputs:

- the character length, from 5 to 9 data bits;
- the parity, which is none, even or odd;
- the number of stop bits, one or two.

Data bits arrive least significant first. The receiver rebuilds each character, recomputes its parity and checks its stop bit. It then places the character in a holding register. Three error flags are kept with each character.

The host learns that a character is waiting from a receive-complete flag. It may also enable an interrupt request for this. The host takes the character by pulsing a read strobe.

A character that completes while the previous one is still unread replaces the old one and is marked as an overrun. When reception is disabled, the line is ignored. A short low pulse on an idle line is rejected as noise.

Top module: `serial_rx_unit`

## Requirements
- R1: After reset, rd_data, rd_bit8, rx_done, err_frame, err_overrun, err_parity and irq are all 0.
- R2: len_code values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits; any value with len_code[2]=1 selects 9 bits. Bits arrive least significant first. rd_data bits above the character length read 0.
- R3: With 9 data bits, the last data bit received appears on rd_bit8; with fewer bits rd_bit8 is 0.
- R4: par_mode 2'b10 expects even parity and 2'b11 expects odd parity, with one parity bit after the data. Under 2'b00 and 2'b01 no parity bit is sent and err_parity stays 0. A parity bit that does not match sets err_parity.
- R5: err_frame is set when the first stop bit is sampled low. When two stop bits are configured (two_stop=1), the second stop bit is never checked.
- R6: rx_done rises once a character is stored. It clears in the cycle after a rd_strobe pulse, unless a new character is stored in that same cycle.
- R7: A character stored while rx_done is 1 and no read is under way sets err_overrun; the new character replaces the old one.
- R8: irq is 1 exactly when rx_done and irq_en are both 1.
- R9: While rx_en is 0, nothing is received and rx_done stays unchanged.
- R10: A low pulse that is gone before the middle of the start bit (8 ticks after the falling edge) starts no character.
- R11: The three error flags are replaced together with rd_data on every stored character, so a clean character clears errors left by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling tick, 16 per bit period |
| rx_en | input | 1 | Receiver enable |
| len_code | input | 3 | Character length select |
| par_mode | input | 2 | Parity mode |
| two_stop | input | 1 | Two stop bits when 1 |
| serial_in | input | 1 | Asynchronous serial line, idle high |
| rd_strobe | input | 1 | One-cycle read of the holding register |
| irq_en | input | 1 | Receive-complete interrupt enable |
| rd_data | output | 8 | Received data bits 7..0 |
| rd_bit8 | output | 1 | Ninth received data bit |
| rx_done | output | 1 | Unread character available |
| err_frame | output | 1 | Stop bit error of held character |
| err_overrun | output | 1 | Overrun on held character |
| err_parity | output | 1 | Parity error of held character |
| irq | output | 1 | Receive-complete interrupt request |

## Verification
A tick counter or bit counter that drifts shows up on the very next character:

- the data bits come out shifted in rd_data;
- or a data bit is read where the stop bit should be, raising a false err_frame;
- or a wrong parity accumulator flips err_parity.

A receiver that gets stuck out of idle shows up as rx_done never rising for a complete frame. Errors in the holding register show at the ports within one cycle of a read strobe or a stored character:

- a missing rx_done clear;
- an overrun that is not raised, or is raised without cause.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    // Number of data bits for a length code: 0..3 -> 5..8, code[2] set -> 9
    function automatic logic [3:0] bits_for(input logic [2:0] code);
        return code[2] ? 4'd9 : ({2'b00, code[1:0]} + 4'd5);
    endfunction

endpackage

// File: rtl/ser_rx_sync.sv
module ser_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic serial_in,
    output logic line,
    output logic fall
);
    typedef struct packed {
        logic meta;
        logic stab;
        logic prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.meta = serial_in;
        sync_d.stab = sync_q.meta;
        sync_d.prev = sync_q.stab;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign line = sync_q.stab;
    assign fall = sync_q.prev & ~sync_q.stab;

endmodule

// File: rtl/ser_rx_frame.sv
module ser_rx_frame
    import ser_rx_pkg::*;
#(
    parameter int OVS      = 16,
    parameter int MAX_BITS = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                rx_en,
    input  logic                line,
    input  logic                fall,
    input  logic [2:0]          len_code,
    input  logic [1:0]          par_mode,
    input  logic                two_stop,
    output logic                out_valid,
    output logic [MAX_BITS-1:0] out_data,
    output logic                out_perr,
    output logic                out_ferr
);
    localparam int CW  = $clog2(OVS);
    localparam int MID = OVS / 2;
    localparam int BW  = 4;

    typedef struct packed {
        rx_state_e           st;
        logic [CW-1:0]       tcnt;
        logic [BW-1:0]       bcnt;
        logic [MAX_BITS-1:0] shr;
        logic                pacc;
        logic                perr;
        logic                ferr;
        logic                vld;
    } frame_t;

    frame_t fr_d, fr_q;
    logic [BW-1:0] nbits;
    logic          bit_end;

    assign nbits   = bits_for(len_code);
    assign bit_end = tick && (fr_q.tcnt == CW'(OVS - 1));

    always_comb begin
        fr_d     = fr_q;
        fr_d.vld = 1'b0;
        case (fr_q.st)
            ST_IDLE: begin
                if (rx_en && fall) begin
                    fr_d.st   = ST_START;
                    fr_d.tcnt = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (fr_q.tcnt == CW'(MID - 1)) begin
                        fr_d.tcnt = '0;
                        if (line) begin
                            fr_d.st = ST_IDLE;
                        end else begin
                            fr_d.st   = ST_DATA;
                            fr_d.bcnt = '0;
                            fr_d.shr  = '0;
                            fr_d.pacc = 1'b0;
                            fr_d.perr = 1'b0;
                        end
                    end else begin
                        fr_d.tcnt = fr_q.tcnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (bit_end) begin
                    fr_d.tcnt = '0;
                    for (int i = 0; i < MAX_BITS; i++) begin
                        if (fr_q.bcnt == BW'(i)) fr_d.shr[i] = line;
                    end
                    fr_d.pacc = fr_q.pacc ^ line;
                    if (fr_q.bcnt == BW'(nbits - 4'd1)) begin
                        fr_d.st = par_mode[1] ? ST_PAR : ST_STOP1;
                    end else begin
                        fr_d.bcnt = fr_q.bcnt + 1'b1;
                    end
                end else if (tick) begin
                    fr_d.tcnt = fr_q.tcnt + 1'b1;
                end
            end
            ST_PAR: begin
                if (bit_end) begin
                    fr_d.tcnt = '0;
                    fr_d.perr = fr_q.pacc ^ line ^ par_mode[0];
                    fr_d.st   = ST_STOP1;
                end else if (tick) begin
                    fr_d.tcnt = fr_q.tcnt + 1'b1;
                end
            end
            ST_STOP1: begin
                if (bit_end) begin
                    fr_d.tcnt = '0;
                    fr_d.ferr = ~line;
                    fr_d.vld  = 1'b1;
                    fr_d.st   = two_stop ? ST_STOP2 : ST_IDLE;
                end else if (tick) begin
                    fr_d.tcnt = fr_q.tcnt + 1'b1;
                end
            end
            ST_STOP2: begin
                if (bit_end) begin
                    fr_d.tcnt = '0;
                    fr_d.st   = ST_IDLE;
                end else if (tick) begin
                    fr_d.tcnt = fr_q.tcnt + 1'b1;
                end
            end
            default: fr_d.st = ST_IDLE;
        endcase
        if (!rx_en) begin
            fr_d.st  = ST_IDLE;
            fr_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q      <= '0;
            fr_q.st   <= ST_IDLE;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign out_valid = fr_q.vld;
    assign out_data  = fr_q.shr;
    assign out_perr  = fr_q.perr;
    assign out_ferr  = fr_q.ferr;

    // R9: a disabled receiver sits in idle
    p_disabled_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> fr_q.st == ST_IDLE);
    // R2: the bit counter never passes the largest character
    p_bitcnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.bcnt < BW'(MAX_BITS));
    // R6: a completed character is announced for one cycle only
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.vld |=> !fr_q.vld);

endmodule

// File: rtl/ser_rx_hold.sv
module ser_rx_hold #(
    parameter int MAX_BITS = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [MAX_BITS-1:0] in_data,
    input  logic                in_perr,
    input  logic                in_ferr,
    input  logic                rd_strobe,
    output logic [MAX_BITS-1:0] held_data,
    output logic                done,
    output logic                ferr,
    output logic                perr,
    output logic                ovr
);
    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                done;
        logic                ferr;
        logic                perr;
        logic                ovr;
    } hold_t;

    hold_t hd_d, hd_q;

    always_comb begin
        hd_d = hd_q;
        if (rd_strobe) hd_d.done = 1'b0;
        if (in_valid) begin
            hd_d.data = in_data;
            hd_d.ferr = in_ferr;
            hd_d.perr = in_perr;
            hd_d.ovr  = hd_q.done & ~rd_strobe;
            hd_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hd_q <= '0;
        else        hd_q <= hd_d;
    end

    assign held_data = hd_q.data;
    assign done      = hd_q.done;
    assign ferr      = hd_q.ferr;
    assign perr      = hd_q.perr;
    assign ovr       = hd_q.ovr;

    // R6: a read with no new character empties the register
    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && !in_valid |=> !done);
    // R7: a character landing on an unread one is flagged
    p_overrun_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && done && !rd_strobe |=> ovr);
    // R7: no overrun when the old character was read or absent
    p_no_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (!done || rd_strobe) |=> !ovr);
    // R11: held data only changes with a new character
    p_data_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(held_data));

endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit #(
    parameter int OVS      = 16,
    parameter int MAX_BITS = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rx_en,
    input  logic [2:0] len_code,
    input  logic [1:0] par_mode,
    input  logic       two_stop,
    input  logic       serial_in,
    input  logic       rd_strobe,
    input  logic       irq_en,
    output logic [7:0] rd_data,
    output logic       rd_bit8,
    output logic       rx_done,
    output logic       err_frame,
    output logic       err_overrun,
    output logic       err_parity,
    output logic       irq
);
    logic                line, fall;
    logic                c_valid, c_perr, c_ferr;
    logic [MAX_BITS-1:0] c_data, h_data;

    ser_rx_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .serial_in (serial_in),
        .line      (line),
        .fall      (fall)
    );

    ser_rx_frame #(.OVS(OVS), .MAX_BITS(MAX_BITS)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .rx_en     (rx_en),
        .line      (line),
        .fall      (fall),
        .len_code  (len_code),
        .par_mode  (par_mode),
        .two_stop  (two_stop),
        .out_valid (c_valid),
        .out_data  (c_data),
        .out_perr  (c_perr),
        .out_ferr  (c_ferr)
    );

    ser_rx_hold #(.MAX_BITS(MAX_BITS)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (c_valid),
        .in_data   (c_data),
        .in_perr   (c_perr),
        .in_ferr   (c_ferr),
        .rd_strobe (rd_strobe),
        .held_data (h_data),
        .done      (rx_done),
        .ferr      (err_frame),
        .perr      (err_parity),
        .ovr       (err_overrun)
    );

    assign rd_data = h_data[7:0];
    assign rd_bit8 = h_data[8];
    assign irq     = rx_done & irq_en;

    // R8: no request while the enable is low
    p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

endmodule

// File: tb/serial_rx_unit_tb.sv
module serial_rx_unit_tb;

    localparam int BITCLK = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16;
    logic [1:0] div = '0;
    logic       rx_en = 1'b1;
    logic [2:0] len_code = 3'd3;
    logic [1:0] par_mode = 2'b00;
    logic       two_stop = 1'b0;
    logic       serial_in = 1'b1;
    logic       rd_strobe = 1'b0;
    logic       irq_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_bit8, rx_done, err_frame, err_overrun, err_parity, irq;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;
    always @(posedge clk) div <= div + 2'd1;
    assign tick16 = (div == 2'd3);

    serial_rx_unit u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_en(rx_en),
        .len_code(len_code), .par_mode(par_mode), .two_stop(two_stop),
        .serial_in(serial_in), .rd_strobe(rd_strobe), .irq_en(irq_en),
        .rd_data(rd_data), .rd_bit8(rd_bit8), .rx_done(rx_done),
        .err_frame(err_frame), .err_overrun(err_overrun),
        .err_parity(err_parity), .irq(irq)
    );

    // {data9, len_code, par_mode, two_stop, bad_stop, bad_par}
    localparam int NV = 8;
    localparam logic [16:0] VEC [NV] = '{
        {9'h0A5, 3'd3, 2'b00, 1'b0, 1'b0, 1'b0},
        {9'h1F3, 3'd0, 2'b10, 1'b0, 1'b0, 1'b0},
        {9'h07E, 3'd1, 2'b11, 1'b1, 1'b0, 1'b0},
        {9'h155, 3'd2, 2'b10, 1'b0, 1'b0, 1'b1},
        {9'h1C3, 3'd4, 2'b11, 1'b0, 1'b0, 1'b0},
        {9'h0FF, 3'd3, 2'b01, 1'b0, 1'b1, 1'b0},
        {9'h12C, 3'd7, 2'b00, 1'b1, 1'b0, 1'b0},
        {9'h03C, 3'd3, 2'b11, 1'b0, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int nbits_of(input logic [2:0] code);
        return code[2] ? 9 : int'(code[1:0]) + 5;
    endfunction

    task automatic hold_line(input logic v);
        serial_in = v;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] dat, input logic bad_stop,
                        input logic bad_par, input logic bad_stop2);
        int nb;
        logic p;
        nb = nbits_of(len_code);
        p = par_mode[0] ^ bad_par;
        hold_line(1'b0);
        for (int i = 0; i < nb; i++) begin
            p = p ^ dat[i];
            hold_line(dat[i]);
        end
        if (par_mode[1]) hold_line(p);
        hold_line(~bad_stop);
        if (two_stop) hold_line(~bad_stop2);
        serial_in = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [8:0] d9;
        logic [8:0] expv;
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 rd_data", rd_data, 0);
        check("R1 rx_done", rx_done, 0);
        check("R1 flags", {rd_bit8, err_frame, err_overrun, err_parity, irq}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 after release", {rx_done, irq}, 0);

        for (int v = 0; v < NV; v++) begin
            d9       = VEC[v][16:8];
            len_code = VEC[v][7:5];
            par_mode = VEC[v][4:3];
            two_stop = VEC[v][2];
            send(d9, VEC[v][1], VEC[v][0], 1'b0);
            expv = d9 & 9'((1 << nbits_of(len_code)) - 1);
            check("R2 data", rd_data, expv[7:0]);
            check("R3 ninth bit", rd_bit8, expv[8]);
            check("R6 done set", rx_done, 1);
            check("R4 parity flag", err_parity, VEC[v][0] & par_mode[1]);
            check("R5 frame flag", err_frame, VEC[v][1]);
            check("R11 overrun clear", err_overrun, 0);
            do_read();
            check("R6 done cleared", rx_done, 0);
        end

        // R5: the second stop bit is not checked
        len_code = 3'd3; par_mode = 2'b00; two_stop = 1'b1;
        send(9'h05A, 1'b0, 1'b0, 1'b1);
        check("R5 stop2 ignored", err_frame, 0);
        check("R5 stop2 data", rd_data, 8'h5A);
        two_stop = 1'b0;

        // R8: interrupt follows done and enable
        check("R8 irq off", irq, 0);
        irq_en = 1'b1;
        @(negedge clk);
        check("R8 irq on", irq, 1);
        do_read();
        check("R8 irq after read", irq, 0);
        irq_en = 1'b0;

        // R7: overrun
        send(9'h011, 1'b0, 1'b0, 1'b0);
        send(9'h022, 1'b0, 1'b0, 1'b0);
        check("R7 overrun set", err_overrun, 1);
        check("R7 new data kept", rd_data, 8'h22);
        do_read();
        send(9'h033, 1'b0, 1'b0, 1'b0);
        check("R11 overrun replaced", err_overrun, 0);
        do_read();

        // R9: disabled receiver captures nothing
        rx_en = 1'b0;
        send(9'h0C0, 1'b0, 1'b0, 1'b0);
        check("R9 no capture", rx_done, 0);
        check("R9 data unchanged", rd_data, 8'h33);
        rx_en = 1'b1;
        repeat (10) @(negedge clk);

        // R10: short glitch rejected
        serial_in = 1'b0;
        repeat (12) @(negedge clk);
        serial_in = 1'b1;
        repeat (400) @(negedge clk);
        check("R10 glitch rejected", rx_done, 0);
        send(9'h07D, 1'b0, 1'b0, 1'b0);
        check("R10 next frame ok", rd_data, 8'h7D);

        finish_run();
    end

endmodule